// File: doc/BRIEF.md
# UART Receive Error Flag Controller

This block holds the sticky error status of a UART receiver: overrun, noise, framing error and parity error. It sits between the bit-level receiver and the small receive data buffer. Each cycle in which the receiver reports a finished character, the block classifies that character. It decides whether the character is written into the buffer, together with a parity-error tag for that word, and which flags it raises.

Overrun takes priority over everything else. When a character finishes while the buffer is full, or while a detected line break is still unacknowledged, the character is discarded and no other flag may set. While the overrun flag stays set, every later character is treated the same way, and the data-ready and idle indications are held back. A framing error keeps its word in the buffer and then halts reception until software clears it.

Software clears the flags in two steps. A read of the status register records which flags are set at that moment. The next read of the data register clears only those recorded flags. A flag that sets again in the same cycle as the clear stays set.

Top module: `uart_rx_errflag_ctrl`

## Requirements
- R1: After synchronous active-low reset, all four flags, `rx_inhibit`, `rdy_block` and `store_en` are 0.
- R2: An accepted character (`char_done`=1 while `frame_flag`=0) that finds `buf_has_room`=0 is an overrun. `store_en` is 0 in that cycle and `ovr_flag` is 1 from the next cycle.
- R3: An overrun character raises none of `noise_flag`, `frame_flag` or `par_flag`.
- R4: While `ovr_flag` is 1, every accepted character counts as an overrun: it is not stored even when the buffer has room. `rdy_block` equals `ovr_flag`.
- R5: A stored character sets `frame_flag` when `stop_bit_a` is 0, or when `two_stop_mode` is 1 and `stop_bit_b` is 0. The character is still stored (`store_en`=1).
- R6: While `frame_flag` is 1, `rx_inhibit` is 1 and `char_done` is ignored: nothing is stored and no flag changes.
- R7: With `brk_det_en`=1, `noise_flag` and `frame_flag` never set.
- R8: A stored character sets `par_flag`, and drives `store_par_tag`=1 beside `store_en`, exactly when `parity_en`=1 and `parity_bad`=1.
- R9: An accepted character that finishes while `brk_det_en`=1 and `brk_pending`=1 is an overrun, even when the buffer has room.
- R10: A flag clears only when a `data_rd` pulse follows a `stat_rd` pulse that saw that flag set. A `data_rd` with no prior `stat_rd` clears nothing.
- R11: A flag that first sets between the `stat_rd` and the following `data_rd` is not cleared by that `data_rd`.
- R12: When a set event and a clear of the same flag fall in one cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_done | input | 1 | One-cycle pulse: a character's last stop bit has been sampled |
| stop_bit_a | input | 1 | Sampled value of the first stop bit |
| stop_bit_b | input | 1 | Sampled value of the second stop bit |
| two_stop_mode | input | 1 | 1 when frames carry two stop bits |
| noise_seen | input | 1 | Receiver saw noise during this character |
| parity_en | input | 1 | Parity checking enabled |
| parity_bad | input | 1 | Received parity bit mismatches computed parity |
| brk_det_en | input | 1 | Line-break detection enabled |
| brk_pending | input | 1 | A detected break is not yet acknowledged |
| buf_has_room | input | 1 | Receive buffer can take another word |
| stat_rd | input | 1 | Bus read strobe of the status register |
| data_rd | input | 1 | Bus read strobe of the data register |
| ovr_flag | output | 1 | Sticky overrun flag |
| noise_flag | output | 1 | Sticky noise flag |
| frame_flag | output | 1 | Sticky framing-error flag |
| par_flag | output | 1 | Sticky parity-error flag |
| store_en | output | 1 | Write the current character into the buffer |
| store_par_tag | output | 1 | Parity-error tag written with the word |
| rdy_block | output | 1 | Holds back data-ready and idle from rising |
| rx_inhibit | output | 1 | Halts further reception |

## Verification
The checker runs on every cycle. It checks that an overrun character is never stored and always raises the overrun flag, and that it leaves the noise and parity flags alone. It also checks that no storage happens while overrun or framing is pending, that break detection keeps noise and framing clear, that a parity tag appears only on a stored word with a parity mismatch, and that the overrun flag falls only on a data read. Only the bench's scenarios can show that the sweep over every input combination of a character gives the right outcome. The same holds for the two-step clear: that it clears exactly the flags recorded at the status read, that a lone data read clears nothing, and that a set in the clearing cycle wins.

// File: rtl/uart_rx_errflag_pkg.sv
// Shared definitions for the receive error flag controller.
// Assumes the four flags are kept as one vector, indexed by the constants below.
package uart_rx_errflag_pkg;
    localparam int FLAG_W    = 4;
    localparam int IDX_PAR   = 0;
    localparam int IDX_FRAME = 1;
    localparam int IDX_NOISE = 2;
    localparam int IDX_OVR   = 3;
    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/errflag_event_eval.sv
// Classifies one finished character into store / tag / flag-set events.
// Assumes char_done is a single-cycle pulse and that flag state is registered elsewhere.
module errflag_event_eval
    import uart_rx_errflag_pkg::*;
(
    input  logic      char_done,
    input  logic      stop_bit_a,
    input  logic      stop_bit_b,
    input  logic      two_stop_mode,
    input  logic      noise_seen,
    input  logic      parity_en,
    input  logic      parity_bad,
    input  logic      brk_det_en,
    input  logic      brk_pending,
    input  logic      buf_has_room,
    input  logic      ovr_held,
    input  logic      frame_held,
    output logic      store_en,
    output logic      store_par_tag,
    output flag_vec_t set_vec
);
    logic accept;
    logic ovr_evt;
    logic stop_bad;

    // Decide acceptance, overrun priority and the per-flag set events.
    always_comb begin
        accept   = char_done && !frame_held;
        ovr_evt  = accept && (!buf_has_room || ovr_held || (brk_det_en && brk_pending));
        stop_bad = !stop_bit_a || (two_stop_mode && !stop_bit_b);
        store_en = accept && !ovr_evt;
        store_par_tag = store_en && parity_en && parity_bad;
        set_vec             = '0;
        set_vec[IDX_OVR]    = ovr_evt;
        set_vec[IDX_NOISE]  = store_en && noise_seen && !brk_det_en;
        set_vec[IDX_FRAME]  = store_en && stop_bad && !brk_det_en;
        set_vec[IDX_PAR]    = store_par_tag;
    end
endmodule

// File: rtl/errflag_clear_ctrl.sv
// Two-step clear: a status read records the flags then set; the next data read
// clears exactly those. Assumes a status read in the same cycle as a data read
// re-arms with the current flags after the data read uses the previous record.
module errflag_clear_ctrl
    import uart_rx_errflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  flag_vec_t flags,
    output flag_vec_t clr_vec
);
    logic      armed;
    flag_vec_t snap;

    // Record the flags seen by a status read; disarm on the data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            snap  <= '0;
        end else if (stat_rd) begin
            armed <= 1'b1;
            snap  <= flags;
        end else if (data_rd) begin
            armed <= 1'b0;
            snap  <= '0;
        end
    end

    // Produce the clear pulse for the recorded flags.
    always_comb clr_vec = (armed && data_rd) ? snap : '0;
endmodule

// File: rtl/errflag_sticky_bank.sv
// Bank of sticky flags where a set beats a clear in the same cycle.
// Assumes set and clear vectors are single-cycle pulses.
module errflag_sticky_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= set_vec[i] || (flags[i] && !clr_vec[i]);
        end
    end
endmodule

// File: rtl/uart_rx_errflag_ctrl.sv
// Top of the receive error flag controller: event evaluation, sticky flag
// bank and two-step clear. Assumes a bit-level receiver drives the per-character
// inputs and a bus decoder produces single-cycle read strobes.
module uart_rx_errflag_ctrl
    import uart_rx_errflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_done,
    input  logic stop_bit_a,
    input  logic stop_bit_b,
    input  logic two_stop_mode,
    input  logic noise_seen,
    input  logic parity_en,
    input  logic parity_bad,
    input  logic brk_det_en,
    input  logic brk_pending,
    input  logic buf_has_room,
    input  logic stat_rd,
    input  logic data_rd,
    output logic ovr_flag,
    output logic noise_flag,
    output logic frame_flag,
    output logic par_flag,
    output logic store_en,
    output logic store_par_tag,
    output logic rdy_block,
    output logic rx_inhibit
);
    flag_vec_t flags;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;

    errflag_event_eval u_eval (
        .char_done     (char_done),
        .stop_bit_a    (stop_bit_a),
        .stop_bit_b    (stop_bit_b),
        .two_stop_mode (two_stop_mode),
        .noise_seen    (noise_seen),
        .parity_en     (parity_en),
        .parity_bad    (parity_bad),
        .brk_det_en    (brk_det_en),
        .brk_pending   (brk_pending),
        .buf_has_room  (buf_has_room),
        .ovr_held      (flags[IDX_OVR]),
        .frame_held    (flags[IDX_FRAME]),
        .store_en      (store_en),
        .store_par_tag (store_par_tag),
        .set_vec       (set_vec)
    );

    errflag_sticky_bank #(.WIDTH(FLAG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    errflag_clear_ctrl u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .flags   (flags),
        .clr_vec (clr_vec)
    );

    // Expose flags and the suppression / inhibit controls they imply.
    always_comb begin
        ovr_flag   = flags[IDX_OVR];
        noise_flag = flags[IDX_NOISE];
        frame_flag = flags[IDX_FRAME];
        par_flag   = flags[IDX_PAR];
        rdy_block  = flags[IDX_OVR];
        rx_inhibit = flags[IDX_FRAME];
    end
endmodule

// File: rtl/uart_rx_errflag_chk.sv
// Checker for the receive error flag controller, bound into the top module.
module uart_rx_errflag_chk (
    input logic clk,
    input logic rst_n,
    input logic char_done,
    input logic brk_det_en,
    input logic buf_has_room,
    input logic parity_en,
    input logic parity_bad,
    input logic data_rd,
    input logic ovr_flag,
    input logic noise_flag,
    input logic frame_flag,
    input logic par_flag,
    input logic store_en,
    input logic store_par_tag,
    input logic rx_inhibit
);
    assert_ovr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !frame_flag && !buf_has_room) |=> ovr_flag);
    assert_ovr_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !buf_has_room) |-> !store_en);
    assert_ovr_blocks_noise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !buf_has_room && !noise_flag) |=> !noise_flag);
    assert_ovr_blocks_par_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !buf_has_room && !par_flag) |=> !par_flag);
    assert_ovr_holds_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> !store_en);
    assert_frame_inhibits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_flag |-> (rx_inhibit && !store_en));
    assert_brk_no_noise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && brk_det_en && !noise_flag) |=> !noise_flag);
    assert_brk_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && brk_det_en && !frame_flag) |=> !frame_flag);
    assert_tag_needs_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_par_tag |-> (store_en && parity_en && parity_bad));
    assert_ovr_clears_on_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !data_rd) |=> ovr_flag);
endmodule

bind uart_rx_errflag_ctrl uart_rx_errflag_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_done     (char_done),
    .brk_det_en    (brk_det_en),
    .buf_has_room  (buf_has_room),
    .parity_en     (parity_en),
    .parity_bad    (parity_bad),
    .data_rd       (data_rd),
    .ovr_flag      (ovr_flag),
    .noise_flag    (noise_flag),
    .frame_flag    (frame_flag),
    .par_flag      (par_flag),
    .store_en      (store_en),
    .store_par_tag (store_par_tag),
    .rx_inhibit    (rx_inhibit)
);

// File: tb/tb_uart_rx_errflag_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rx_errflag_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_done = 0, stop_bit_a = 1, stop_bit_b = 1, two_stop_mode = 0;
    logic noise_seen = 0, parity_en = 0, parity_bad = 0, brk_det_en = 0;
    logic brk_pending = 0, buf_has_room = 1, stat_rd = 0, data_rd = 0;
    logic ovr_flag, noise_flag, frame_flag, par_flag;
    logic store_en, store_par_tag, rdy_block, rx_inhibit;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #2.5 clk = ~clk;

    uart_rx_errflag_ctrl dut (.*);

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one character at a negedge; sample combinational store outputs.
    task automatic send_char(input logic [8:0] v, output logic st, output logic tg);
        {stop_bit_a, stop_bit_b, two_stop_mode, noise_seen, parity_en,
         parity_bad, brk_det_en, brk_pending, buf_has_room} = v;
        char_done = 1'b1;
        #1;
        st = store_en;
        tg = store_par_tag;
        @(posedge clk);
        @(negedge clk);
        char_done = 1'b0;
        {stop_bit_a, stop_bit_b, two_stop_mode, noise_seen, parity_en,
         parity_bad, brk_det_en, brk_pending, buf_has_room} = 9'b110000001;
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic pulse_data();
        data_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    // Clean character bits: stop_a,stop_b,two_stop,noise,pe,pbad,brk_en,brk_p,room
    localparam logic [8:0] CLEAN   = 9'b110000001;
    localparam logic [8:0] NOROOM  = 9'b110000000;
    localparam logic [8:0] PARERR  = 9'b110011001;
    localparam logic [8:0] NOISY   = 9'b110100001;
    localparam logic [8:0] BADSTOP = 9'b010000001;

    initial begin
        logic st, tg;
        do_reset();
        // R1: reset state
        chk(ovr_flag,   1'b0, "R1", "ovr after reset");
        chk(noise_flag, 1'b0, "R1", "noise after reset");
        chk(frame_flag, 1'b0, "R1", "frame after reset");
        chk(par_flag,   1'b0, "R1", "par after reset");
        chk(rx_inhibit, 1'b0, "R1", "inhibit after reset");
        chk(rdy_block,  1'b0, "R1", "block after reset");
        chk(store_en,   1'b0, "R1", "store after reset");

        // Exhaustive sweep over every input combination of one character from the reset state.
        for (int c = 0; c < 512; c++) begin
            logic [8:0] v;
            logic s1, s2, ts, nz, pe, pb, be, bp, rm;
            logic e_ovr, e_st, e_nz, e_fr, e_pr;
            v = 9'(c);
            {s1, s2, ts, nz, pe, pb, be, bp, rm} = v;
            e_ovr = !rm || (be && bp);
            e_st  = !e_ovr;
            e_nz  = e_st && nz && !be;
            e_fr  = e_st && !be && (!s1 || (ts && !s2));
            e_pr  = e_st && pe && pb;
            do_reset();
            send_char(v, st, tg);
            chk(st, e_st, e_ovr ? "R2/R9" : "R5", $sformatf("store v=%b", v));
            chk(tg, e_pr, "R8", $sformatf("tag v=%b", v));
            chk(ovr_flag,   e_ovr, (be && bp) ? "R9" : "R2", $sformatf("ovr v=%b", v));
            chk(noise_flag, e_nz, "R3/R7", $sformatf("noise v=%b", v));
            chk(frame_flag, e_fr, "R5/R7", $sformatf("frame v=%b", v));
            chk(par_flag,   e_pr, "R3/R8", $sformatf("par v=%b", v));
            chk(rdy_block,  e_ovr, "R4", $sformatf("block v=%b", v));
            chk(rx_inhibit, e_fr, "R6", $sformatf("inhibit v=%b", v));
            pulse_stat();
            pulse_data();
            chk(|{ovr_flag, noise_flag, frame_flag, par_flag, rx_inhibit}, 1'b0,
                "R10", $sformatf("two-step clear v=%b", v));
        end

        // R4: overrun held blocks storage even with room; blocks noise as well.
        do_reset();
        send_char(NOROOM, st, tg);
        send_char(CLEAN, st, tg);
        chk(st, 1'b0, "R4", "store while ovr held");
        chk(rdy_block, 1'b1, "R4", "block while ovr held");
        send_char(NOISY, st, tg);
        chk(noise_flag, 1'b0, "R4", "noise while ovr held");

        // R6: framing error inhibits reception.
        do_reset();
        send_char(BADSTOP, st, tg);
        chk(st, 1'b1, "R5", "frame word stored");
        send_char(NOISY, st, tg);
        chk(st, 1'b0, "R6", "store while inhibited");
        chk(noise_flag, 1'b0, "R6", "noise while inhibited");
        send_char(NOROOM, st, tg);
        chk(ovr_flag, 1'b0, "R6", "ovr while inhibited");
        pulse_stat();
        pulse_data();
        chk(rx_inhibit, 1'b0, "R10", "inhibit released");

        // R10: lone data read clears nothing.
        do_reset();
        send_char(PARERR, st, tg);
        pulse_data();
        chk(par_flag, 1'b1, "R10", "lone data read");
        pulse_stat();
        pulse_data();
        chk(par_flag, 1'b0, "R10", "stat then data");

        // R11: flag set between reads survives.
        do_reset();
        send_char(PARERR, st, tg);
        pulse_stat();
        send_char(NOISY, st, tg);
        pulse_data();
        chk(par_flag,   1'b0, "R11", "recorded flag cleared");
        chk(noise_flag, 1'b1, "R11", "late flag kept");

        // R12: set and clear in the same cycle, set wins.
        do_reset();
        send_char(PARERR, st, tg);
        pulse_stat();
        data_rd = 1'b1;
        send_char(PARERR, st, tg);
        data_rd = 1'b0;
        chk(par_flag, 1'b1, "R12", "set beats clear");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog all actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule